// File: doc/BRIEF.md
# Staged Reset One-Shot

This block produces the reset for a small controller card in two steps from one clocked shift register. A trigger places a token at the head of the register. While the token passes the lower stages it holds the local processor in reset. Device reset starts two stages later and lasts until the token leaves the last stage. Device reset therefore starts after processor reset, and processor reset ends while device reset is still active. After a fixed number of clocks set by the register length, both outputs go low on a clock edge and stay low until the next trigger.

The sequence has two sources. One is a host interface-clear line, which is asynchronous to the card clock. The other is a trigger bit in a register that firmware writes. The host line passes through a two-flop synchronizer and then an edge detector, so a line held high starts only one sequence. The firmware bit is stored in a register and acts on its rising edge. Device reset clears the stored bit, so after a sequence firmware can start another by writing the bit again. A trigger that arrives during a sequence restarts both release points from that trigger, and neither output drops in between.

Top module: `staged_reset_oneshot`

## Requirements
- R1: A write (`fw_wr_i` high) with `fw_wdata_i[5]` = 1 while the stored trigger bit is 0 makes `cpu_rst_o` high after the next clock edge, one edge after the write edge.
- R2: A rising edge on `host_clear_i` makes `cpu_rst_o` high after the third clock edge at which the line is sampled high: two edges for the synchronizer, one for the load.
- R3: Counting from the load edge as cycle 0, `cpu_rst_o` is high in cycles 0 to 3 and `dev_rst_o` is high in cycles 2 to 7. Device reset never rises while processor reset is low, and processor reset falls while device reset is still high.
- R4: If `host_clear_i` stays high, only one sequence starts.
- R5: A write with bit 5 set while the stored bit is already 1 has no effect. While `dev_rst_o` is high the stored bit is held at 0 and writes are ignored. A write after the sequence ends starts a new one.
- R6: A write with bit 5 = 0 starts nothing, whatever the other data bits hold.
- R7: A trigger during an active sequence restarts the timing from its own load edge: processor reset for cycles 0 to 3 and device reset up to cycle 7. Neither output goes low in between.
- R8: When `rst_n` is low, both outputs are low at once, and the stored trigger bit is cleared.
- R9: Both outputs come from flops, change only on clock edges, and stay low after a sequence until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_clear_i | input | 1 | Host interface-clear request, active high, asynchronous |
| fw_wr_i | input | 1 | Write strobe for the control register |
| fw_wdata_i | input | 8 | Control register write data; bit 5 is the trigger bit |
| cpu_rst_o | output | 1 | Processor reset, active high |
| dev_rst_o | output | 1 | Reset for all other devices, active high |

## Verification
The assertions assume that `rst_n` is low at the start. They also assume that the firmware write strobe and data are synchronous to `clk` and steady across the edge that samples them, and that a host clear pulse lasts at least one clock so the synchronizer sees it. The stimulus changes every input on the falling edge, holds each host pulse for at least one full cycle, and drives `rst_n` low in the middle of a sequence only as a directed test of the asynchronous path. The checker times both reset windows against a counter it restarts on every trigger, so a retrigger in the middle of a sequence is checked against the newest load edge.

// File: rtl/srs_pkg.sv
package srs_pkg;

  // Default geometry of the staged reset
  localparam int unsigned SRS_LEN      = 8;  // shift register stages
  localparam int unsigned SRS_CPU_HI   = 3;  // last stage that holds processor reset
  localparam int unsigned SRS_DEV_LO   = 2;  // first stage that holds device reset
  localparam int unsigned SRS_SYNC     = 2;  // host line synchronizer depth
  localparam int unsigned SRS_CTL_W    = 8;  // control register width
  localparam int unsigned SRS_TRIG_BIT = 5;  // trigger bit position in the control register

  typedef struct packed {
    logic cpu;
    logic dev;
  } srs_rst_t;

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb ff_d = d_i;
    end else begin : g_chain
      always_comb ff_d = {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/srs_rise.sv
module srs_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~prev_q;

endmodule

// File: rtl/srs_ctl_bit.sv
module srs_ctl_bit #(
  parameter int unsigned CTL_W    = 8,
  parameter int unsigned TRIG_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             clr_i,
  output logic             bit_o
);

  logic bit_q;
  logic bit_d;
  logic bit_en;

  // Clear from device reset wins over a write in the same cycle
  always_comb begin
    bit_en = clr_i | wr_i;
    if (clr_i) bit_d = 1'b0;
    else       bit_d = wdata_i[TRIG_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bit_q <= 1'b0;
    else if (bit_en) bit_q <= bit_d;
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/srs_chain.sv
module srs_chain
  import srs_pkg::*;
#(
  parameter int unsigned LEN    = 8,
  parameter int unsigned CPU_HI = 3,
  parameter int unsigned DEV_LO = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     trig_i,
  output srs_rst_t rst_o
);

  localparam int unsigned DEV_HI = LEN - 1;

  function automatic logic [LEN-1:0] band_mask(input int unsigned lo, input int unsigned hi);
    logic [LEN-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < LEN; i++) begin
      if (i >= lo && i <= hi) m = m | (LEN'(1) << i);
    end
    return m;
  endfunction

  localparam logic [LEN-1:0] CPU_MASK = band_mask(0, CPU_HI);
  localparam logic [LEN-1:0] DEV_MASK = band_mask(DEV_LO, DEV_HI);

  logic [LEN-1:0] stg_q;
  logic [LEN-1:0] stg_d;
  logic [LEN-1:0] fill;
  logic [LEN-1:0] shifted;
  logic           stg_en;
  srs_rst_t       rst_q;
  srs_rst_t       rst_d;

  // Retrigger fill: a new token at the head, and every stage between
  // the head and the oldest live token set, so no output gap appears
  // and both release points move to the new load edge.
  generate
    for (genvar i = 0; i < LEN; i++) begin : g_fill
      if (i == 0) begin : g_head
        assign fill[i] = 1'b1;
      end else begin : g_body
        assign fill[i] = |stg_q[LEN-1:i-1];
      end
    end
  endgenerate

  always_comb begin
    shifted = {stg_q[LEN-2:0], 1'b0};
    stg_en  = trig_i | (|stg_q);
    stg_d   = trig_i ? fill : shifted;
    rst_d.cpu = |(stg_d & CPU_MASK);
    rst_d.dev = |(stg_d & DEV_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stg_q <= '0;
    else if (stg_en) stg_q <= stg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= rst_d;
  end

  assign rst_o = rst_q;

endmodule

// File: rtl/staged_reset_oneshot.sv
module staged_reset_oneshot
  import srs_pkg::*;
#(
  parameter int unsigned LEN         = SRS_LEN,
  parameter int unsigned CPU_HI      = SRS_CPU_HI,
  parameter int unsigned DEV_LO      = SRS_DEV_LO,
  parameter int unsigned SYNC_STAGES = SRS_SYNC,
  parameter int unsigned CTL_W       = SRS_CTL_W,
  parameter int unsigned TRIG_BIT    = SRS_TRIG_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_clear_i,
  input  logic             fw_wr_i,
  input  logic [CTL_W-1:0] fw_wdata_i,
  output logic             cpu_rst_o,
  output logic             dev_rst_o
);

  localparam int unsigned DEV_HI = LEN - 1;

  logic     host_sync;
  logic     host_rise;
  logic     fw_bit;
  logic     fw_rise;
  logic     seq_trig;
  srs_rst_t seq_rst;
  logic     unused_wdata;

  assign unused_wdata = ^fw_wdata_i;

  srs_sync #(.STAGES(SYNC_STAGES)) u_host_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (host_clear_i),
    .q_o   (host_sync)
  );

  srs_rise u_host_rise (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_i   (host_sync),
    .pulse_o (host_rise)
  );

  srs_ctl_bit #(.CTL_W(CTL_W), .TRIG_BIT(TRIG_BIT)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (fw_wr_i),
    .wdata_i (fw_wdata_i),
    .clr_i   (seq_rst.dev),
    .bit_o   (fw_bit)
  );

  srs_rise u_fw_rise (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_i   (fw_bit),
    .pulse_o (fw_rise)
  );

  assign seq_trig = host_rise | fw_rise;

  srs_chain #(.LEN(LEN), .CPU_HI(CPU_HI), .DEV_LO(DEV_LO)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (seq_trig),
    .rst_o  (seq_rst)
  );

  assign cpu_rst_o = seq_rst.cpu;
  assign dev_rst_o = seq_rst.dev;

endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int unsigned LEN    = 8,
  parameter int unsigned CPU_HI = 3,
  parameter int unsigned DEV_HI = 7
) (
  input logic clk,
  input logic rst_n,
  input logic trig,
  input logic cpu_rst,
  input logic dev_rst
);

  localparam int unsigned CNT_MAX = DEV_HI + 2;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  // Cycles since the most recent trigger, saturating (processor window starts at stage 0)
  logic [CW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      since_q <= CW'(CNT_MAX);
    else if (trig)                   since_q <= CW'(1);
    else if (since_q != CW'(CNT_MAX)) since_q <= since_q + CW'(1);
  end

  p_trig_starts_cpu_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cpu_rst);

  p_cpu_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= CW'(1) && since_q <= CW'(CPU_HI + 1)) |-> cpu_rst);

  p_cpu_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q > CW'(CPU_HI + 1)) |-> !cpu_rst);

  p_all_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q == CW'(CNT_MAX)) |-> (!cpu_rst && !dev_rst));

  p_dev_after_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst) |-> cpu_rst);

  p_cpu_before_dev_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst) |-> dev_rst);

  p_rise_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> $past(trig));

endmodule

bind staged_reset_oneshot srs_chk #(
  .LEN    (LEN),
  .CPU_HI (CPU_HI),
  .DEV_HI (DEV_HI)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .trig    (seq_trig),
  .cpu_rst (cpu_rst_o),
  .dev_rst (dev_rst_o)
);

// File: tb/staged_reset_oneshot_tb.sv
`timescale 1ns/1ps
module staged_reset_oneshot_tb;

  logic       clk;
  logic       rst_n;
  logic       host_clear_i;
  logic       fw_wr_i;
  logic [7:0] fw_wdata_i;
  logic       cpu_rst_o;
  logic       dev_rst_o;

  int n_chk;
  int n_bad;
  bit done;

  staged_reset_oneshot u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_clear_i (host_clear_i),
    .fw_wr_i      (fw_wr_i),
    .fw_wdata_i   (fw_wdata_i),
    .cpu_rst_o    (cpu_rst_o),
    .dev_rst_o    (dev_rst_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // Row: {host, wr, data[7:0], exp_cpu, exp_dev, req[3:0]}
  // Expected outputs are sampled on the falling edge after the row's rising edge.
  localparam int NV = 63;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0,1'b0,8'h00,2'b00,4'd8},  // 0  idle after reset (R8)
    {1'b0,1'b1,8'h20,2'b00,4'd1},  // 1  fw write, trigger edge (R1)
    {1'b0,1'b1,8'h20,2'b10,4'd5},  // 2  load; rewrite of set bit ignored (R5)
    {1'b0,1'b0,8'h00,2'b10,4'd1},  // 3
    {1'b0,1'b0,8'h00,2'b11,4'd3},  // 4  device reset joins (R3)
    {1'b0,1'b0,8'h00,2'b11,4'd3},  // 5
    {1'b0,1'b0,8'h00,2'b01,4'd3},  // 6  processor released first (R3)
    {1'b0,1'b0,8'h00,2'b01,4'd3},  // 7
    {1'b0,1'b0,8'h00,2'b01,4'd3},  // 8
    {1'b0,1'b0,8'h00,2'b01,4'd3},  // 9
    {1'b0,1'b0,8'h00,2'b00,4'd9},  // 10 both released (R9)
    {1'b0,1'b0,8'h00,2'b00,4'd9},  // 11
    {1'b1,1'b0,8'h00,2'b00,4'd2},  // 12 host clear held (R2)
    {1'b1,1'b0,8'h00,2'b00,4'd2},  // 13
    {1'b1,1'b0,8'h00,2'b10,4'd2},  // 14 third sampled edge loads (R2)
    {1'b1,1'b0,8'h00,2'b10,4'd3},  // 15
    {1'b1,1'b0,8'h00,2'b11,4'd3},  // 16
    {1'b1,1'b0,8'h00,2'b11,4'd3},  // 17
    {1'b1,1'b0,8'h00,2'b01,4'd3},  // 18
    {1'b1,1'b0,8'h00,2'b01,4'd3},  // 19
    {1'b1,1'b0,8'h00,2'b01,4'd3},  // 20
    {1'b1,1'b0,8'h00,2'b01,4'd3},  // 21
    {1'b1,1'b0,8'h00,2'b00,4'd4},  // 22 still held, no second sequence (R4)
    {1'b1,1'b0,8'h00,2'b00,4'd4},  // 23
    {1'b0,1'b0,8'h00,2'b00,4'd4},  // 24
    {1'b0,1'b1,8'hDF,2'b00,4'd6},  // 25 other bits only (R6)
    {1'b0,1'b0,8'h00,2'b00,4'd6},  // 26
    {1'b0,1'b0,8'h00,2'b00,4'd6},  // 27
    {1'b0,1'b1,8'h20,2'b00,4'd1},  // 28 fw trigger
    {1'b0,1'b0,8'h00,2'b10,4'd1},  // 29
    {1'b1,1'b0,8'h00,2'b10,4'd7},  // 30 host pulse during sequence (R7)
    {1'b0,1'b0,8'h00,2'b11,4'd7},  // 31
    {1'b0,1'b0,8'h00,2'b11,4'd7},  // 32 reload edge
    {1'b0,1'b0,8'h00,2'b11,4'd7},  // 33
    {1'b0,1'b0,8'h00,2'b11,4'd7},  // 34
    {1'b0,1'b0,8'h00,2'b11,4'd7},  // 35
    {1'b0,1'b0,8'h00,2'b01,4'd7},  // 36
    {1'b0,1'b0,8'h00,2'b01,4'd7},  // 37
    {1'b0,1'b0,8'h00,2'b01,4'd7},  // 38
    {1'b0,1'b0,8'h00,2'b01,4'd7},  // 39
    {1'b0,1'b0,8'h00,2'b00,4'd7},  // 40
    {1'b0,1'b0,8'h00,2'b00,4'd9},  // 41
    {1'b0,1'b1,8'h20,2'b00,4'd1},  // 42 fw trigger
    {1'b0,1'b0,8'h00,2'b10,4'd1},  // 43
    {1'b0,1'b0,8'h00,2'b10,4'd1},  // 44
    {1'b0,1'b0,8'h00,2'b11,4'd3},  // 45
    {1'b0,1'b0,8'h00,2'b11,4'd3},  // 46
    {1'b0,1'b1,8'h20,2'b01,4'd5},  // 47 write during device reset ignored (R5)
    {1'b0,1'b0,8'h00,2'b01,4'd5},  // 48
    {1'b0,1'b0,8'h00,2'b01,4'd5},  // 49
    {1'b0,1'b0,8'h00,2'b01,4'd5},  // 50
    {1'b0,1'b0,8'h00,2'b00,4'd5},  // 51
    {1'b0,1'b0,8'h00,2'b00,4'd5},  // 52
    {1'b0,1'b1,8'h20,2'b00,4'd5},  // 53 new write after sequence (R5)
    {1'b0,1'b0,8'h00,2'b10,4'd5},  // 54
    {1'b0,1'b0,8'h00,2'b10,4'd3},  // 55
    {1'b0,1'b0,8'h00,2'b11,4'd3},  // 56
    {1'b0,1'b0,8'h00,2'b11,4'd3},  // 57
    {1'b0,1'b0,8'h00,2'b01,4'd3},  // 58
    {1'b0,1'b0,8'h00,2'b01,4'd3},  // 59
    {1'b0,1'b0,8'h00,2'b01,4'd3},  // 60
    {1'b0,1'b0,8'h00,2'b01,4'd3},  // 61
    {1'b0,1'b0,8'h00,2'b00,4'd9}   // 62 quiet until next trigger (R9)
  };

  task automatic check_out(input int req, input logic [1:0] exp, input string what);
    n_chk++;
    if ({cpu_rst_o, dev_rst_o} !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: cpu/dev actual %b%b expected %b", req, what,
               cpu_rst_o, dev_rst_o, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; host_clear_i = 1'b0; fw_wr_i = 1'b0; fw_wdata_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out(8, 2'b00, "outputs in reset");   // R8
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      host_clear_i = VEC[i][15];
      fw_wr_i      = VEC[i][14];
      fw_wdata_i   = VEC[i][13:6];
      @(negedge clk);
      check_out(int'(VEC[i][3:0]), VEC[i][5:4], $sformatf("vector %0d", i));
    end

    // R8: asynchronous reset in the middle of a sequence
    fw_wr_i = 1'b1; fw_wdata_i = 8'h20;
    @(negedge clk);
    fw_wr_i = 1'b0; fw_wdata_i = 8'h00;
    repeat (3) @(negedge clk);
    check_out(3, 2'b11, "mid sequence before reset");  // R3
    #1 rst_n = 1'b0;
    #1 check_out(8, 2'b00, "immediate async reset");   // R8
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_out(8, 2'b00, "idle after mid-sequence reset");  // R8, R9
    // R8: stored bit was cleared, so a new write triggers again (R1)
    fw_wr_i = 1'b1; fw_wdata_i = 8'h20;
    @(negedge clk);
    fw_wr_i = 1'b0; fw_wdata_i = 8'h00;
    check_out(1, 2'b00, "trigger cycle after reset");
    @(negedge clk);
    check_out(1, 2'b10, "processor reset after reset recovery");
    repeat (10) @(negedge clk);
    check_out(9, 2'b00, "quiet at end");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule